// File: doc/BRIEF.md
# Hashed Page Table Group Searcher

This engine looks up one group of a hashed page table held in memory. The caller supplies a precomputed hash, a 32-bit compare word (a copy of the first word of the wanted entry), three attribute bits from the segment register, the privilege of the access and the access kind. The engine finds the group from the hash and a table configuration word. It reads the group's entries one after another over a 32-bit memory port until one matches. It then fetches that entry's second word, decodes the access rights and reports the real page number, the storage attribute bits, the rights and whether the access is allowed.

On an allowed access, the engine sets the referenced bit of the matching entry. On an allowed store it also sets the changed bit. The second word is written back to memory only when one of these bits was not already set. Choosing the secondary group and retrying is left to the caller, which starts a second search with a different hash and compare word.

Both the request side and the memory side use valid/ready handshakes. A request is taken only while `req_ready` is high, and that happens only when the engine is idle. A memory request holds its valid, address, write flag and data steady until `mem_req_ready` is seen. The memory may stall each request for any number of cycles. Read data comes back on `mem_rsp_valid`, which has no ready signal because the engine always waits for it. At most one read is in flight at a time.

Top module: `hpt_group_search`

## Requirements
- R1: The group address is `(cfg & 0xFFFF0000) + ((hash*64) & (((cfg & 0x1FF) << 16) | 0xFFFF))`. The first word of slot k is read at group address + 8k, and the second word at group address + 8k + 4. All addresses are word aligned.
- R2: The first words are read for slots 0, 1, 2 and so on, in that order. The search stops at the first matching slot and then reads only that slot's second word. If all eight slots miss, the engine finishes with hit=0 and fault=0 and never reads a second word.
- R3: A first word matches when its bit 31 (valid) is 1 and it equals the compare word on every bit in mask 0x7FFFFFBF. Bit 6 (the secondary flag) and bit 31 of the compare word are not compared.
- R4: `req_seg_attr` holds three segment bits: [2] is the supervisor key, [1] is the user key and [0] is no-execute. The key in use is [1] when `req_user`=1 and [2] otherwise.
- R5: The protection field is bits 1:0 of the second word. With key=1: value 0 gives no access, values 1 and 3 give read, and value 2 gives read/write. With key=0: values 0 to 2 give read/write and value 3 gives read.
- R6: Execute is added to the rights unless the no-execute bit is 1. `res_rights` is {execute, write, read}, with read at bit 0.
- R7: `req_acc` 1 (store) needs write, 2 (fetch) needs execute, and 0 or 3 (load) needs read. A matched entry whose rights lack the needed one ends with hit=1 and fault=1, and nothing is written.
- R8: On an allowed access, the second word is written back with bit 8 (referenced) set, and with bit 7 (changed) also set for a store. The write goes to the second word's address only if the value changed; otherwise no write is issued.
- R9: On a hit, `res_rpn` = second word bits 31:12, `res_wimg` = bits 6:3, and `res_slot` = the matching slot index, all taken from the word as read.
- R10: `req_ready` is high only when the engine is idle and no memory request is pending. A memory request keeps valid, address, write flag and data stable until it is accepted. A new read is never issued while a read is still in flight.
- R11: `done` is a single-cycle pulse, one per accepted request. Result outputs are valid in that cycle, and `done` is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_table | input | 32 | Table base (bits 31:16) and size mask (bits 8:0), sampled when a request is taken |
| req_valid | input | 1 | Search request valid |
| req_ready | output | 1 | Engine idle, ready to take a request |
| req_hash | input | HASH_W | Precomputed group hash |
| req_cmp | input | 32 | Compare word for the entry's first word |
| req_seg_attr | input | 3 | {supervisor key, user key, no-execute} |
| req_user | input | 1 | 1 = user privilege |
| req_acc | input | 2 | 0 load, 1 store, 2 fetch, 3 load |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| done | output | 1 | Search finished (one-cycle pulse) |
| hit | output | 1 | A matching entry was found |
| fault | output | 1 | Entry found but the access is not allowed |
| res_rpn | output | 20 | Real page number |
| res_wimg | output | 4 | Storage attribute bits |
| res_rights | output | 3 | {execute, write, read} |
| res_slot | output | SLOT_W | Index of the matching slot |

## Verification
The bench places the match at every slot and also tests a full miss. It puts invalid entries, entries that differ by one compare bit, entries that differ only in the secondary flag, and later duplicate matches in the same group. A design that compared the secondary flag, ignored the valid bit or kept scanning after the first hit would read a different sequence of words or report the wrong slot.

A second sweep covers every protection value, privilege, key polarity, no-execute setting and access kind. Its referenced and changed bits start in varying states, so a design that chose the wrong key bit, let a faulting access write, or rewrote an unchanged word would show the wrong rights or a wrong write count. Random stalls on the memory side, with one- or two-cycle read latency, test that requests are held steady and that reads never overlap.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  localparam int WORD_W = 32;

  // compare mask on the first word: everything but the valid and secondary bits
  localparam logic [WORD_W-1:0] MATCH_MASK = 32'h7FFF_FFBF;
  localparam logic [WORD_W-1:0] BASE_MASK  = 32'hFFFF_0000;

  localparam int W0_VALID_BIT = 31;
  localparam int W1_REF_BIT   = 8;
  localparam int W1_CHG_BIT   = 7;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD0,
    ST_W0,
    ST_RD1,
    ST_W1,
    ST_WB
  } state_e;

  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } rights_t;
endpackage

// File: rtl/hpt_addr_gen.sv
module hpt_addr_gen #(
  parameter int HASH_W      = 19,
  parameter int SLOT_W      = 3,
  parameter int ENTRY_SHIFT = 3,
  parameter int GRP_SHIFT   = 6
) (
  input  logic [31:0]       cfg,
  input  logic [HASH_W-1:0] hash,
  input  logic [SLOT_W-1:0] slot,
  input  logic              second,
  output logic [31:0]       addr
);
  import hpt_pkg::*;

  localparam logic [31:0] HALF_ENTRY = 32'((1 << ENTRY_SHIFT) / 2);

  logic [31:0] tbl_base;
  logic [31:0] tbl_mask;
  logic [31:0] grp_off;
  logic [31:0] slot_off;

  always_comb begin
    tbl_base = cfg & BASE_MASK;
    tbl_mask = {7'd0, cfg[8:0], 16'hFFFF};
    grp_off  = (32'(hash) << GRP_SHIFT) & tbl_mask;
    slot_off = 32'(slot) << ENTRY_SHIFT;
    addr     = tbl_base + grp_off + slot_off + (second ? HALF_ENTRY : 32'd0);
  end
endmodule

// File: rtl/hpt_entry_match.sv
module hpt_entry_match (
  input  logic [31:0] word0,
  input  logic [31:0] cmp,
  output logic        match
);
  import hpt_pkg::*;

  logic [31:0] diff;

  always_comb begin
    diff  = (word0 ^ cmp) & MATCH_MASK;
    match = word0[W0_VALID_BIT] && (diff == 32'd0);
  end
endmodule

// File: rtl/hpt_rights.sv
module hpt_rights (
  input  logic          key_sup,
  input  logic          key_usr,
  input  logic          no_exec,
  input  logic          user,
  input  logic [1:0]    pp,
  input  logic [1:0]    acc,
  output hpt_pkg::rights_t rights,
  output logic          allowed
);
  import hpt_pkg::*;

  logic key;

  always_comb begin
    key      = user ? key_usr : key_sup;
    rights   = '0;
    if (key) begin
      unique case (pp)
        2'd0:    begin rights.r = 1'b0; rights.w = 1'b0; end
        2'd2:    begin rights.r = 1'b1; rights.w = 1'b1; end
        default: begin rights.r = 1'b1; rights.w = 1'b0; end
      endcase
    end else begin
      unique case (pp)
        2'd3:    begin rights.r = 1'b1; rights.w = 1'b0; end
        default: begin rights.r = 1'b1; rights.w = 1'b1; end
      endcase
    end
    rights.x = !no_exec;

    unique case (acc)
      ACC_STORE: allowed = rights.w;
      ACC_FETCH: allowed = rights.x;
      default:   allowed = rights.r;
    endcase
  end
endmodule

// File: rtl/hpt_group_search.sv
module hpt_group_search #(
  parameter int HASH_W      = 19,
  parameter int NUM_SLOTS   = 8,
  parameter int ENTRY_BYTES = 8,
  localparam int SLOT_W     = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       cfg_table,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [HASH_W-1:0] req_hash,
  input  logic [31:0]       req_cmp,
  input  logic [2:0]        req_seg_attr,
  input  logic              req_user,
  input  logic [1:0]        req_acc,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [31:0]       mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  output logic              done,
  output logic              hit,
  output logic              fault,
  output logic [19:0]       res_rpn,
  output logic [3:0]        res_wimg,
  output logic [2:0]        res_rights,
  output logic [SLOT_W-1:0] res_slot
);
  import hpt_pkg::*;

  localparam int ENTRY_SHIFT           = $clog2(ENTRY_BYTES);
  localparam int GRP_SHIFT             = SLOT_W + ENTRY_SHIFT;
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  state_e              st_q;
  logic [SLOT_W-1:0]   slot_q;
  logic [HASH_W-1:0]   hash_q;
  logic [31:0]         cmp_q;
  logic [31:0]         cfg_q;
  logic [2:0]          attr_q;
  logic                user_q;
  logic [1:0]          acc_q;
  logic [31:0]         wb_q;

  logic                done_q;
  logic                hit_q;
  logic                fault_q;
  logic [19:0]         rpn_q;
  logic [3:0]          wimg_q;
  logic [2:0]          rights_q;
  logic [SLOT_W-1:0]   rslot_q;

  logic                second_word;
  logic [31:0]         gen_addr;
  logic                ent_match;
  rights_t             dec_rights;
  logic                dec_allowed;
  logic [31:0]         upd_word;

  hpt_addr_gen #(
    .HASH_W     (HASH_W),
    .SLOT_W     (SLOT_W),
    .ENTRY_SHIFT(ENTRY_SHIFT),
    .GRP_SHIFT  (GRP_SHIFT)
  ) u_addr (
    .cfg   (cfg_q),
    .hash  (hash_q),
    .slot  (slot_q),
    .second(second_word),
    .addr  (gen_addr)
  );

  hpt_entry_match u_match (
    .word0(mem_rsp_data),
    .cmp  (cmp_q),
    .match(ent_match)
  );

  hpt_rights u_rights (
    .key_sup(attr_q[2]),
    .key_usr(attr_q[1]),
    .no_exec(attr_q[0]),
    .user   (user_q),
    .pp     (mem_rsp_data[1:0]),
    .acc    (acc_q),
    .rights (dec_rights),
    .allowed(dec_allowed)
  );

  always_comb begin
    second_word   = (st_q == ST_RD1) || (st_q == ST_W1) || (st_q == ST_WB);
    req_ready     = (st_q == ST_IDLE);
    mem_req_valid = (st_q == ST_RD0) || (st_q == ST_RD1) || (st_q == ST_WB);
    mem_req_write = (st_q == ST_WB);
    mem_req_addr  = gen_addr;
    mem_req_wdata = wb_q;
    upd_word      = mem_rsp_data;
    upd_word[W1_REF_BIT] = 1'b1;
    if (acc_q == ACC_STORE) upd_word[W1_CHG_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      slot_q   <= '0;
      hash_q   <= '0;
      cmp_q    <= '0;
      cfg_q    <= '0;
      attr_q   <= '0;
      user_q   <= 1'b0;
      acc_q    <= 2'd0;
      wb_q     <= '0;
      done_q   <= 1'b0;
      hit_q    <= 1'b0;
      fault_q  <= 1'b0;
      rpn_q    <= '0;
      wimg_q   <= '0;
      rights_q <= '0;
      rslot_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (req_valid) begin
            hash_q <= req_hash;
            cmp_q  <= req_cmp;
            cfg_q  <= cfg_table;
            attr_q <= req_seg_attr;
            user_q <= req_user;
            acc_q  <= req_acc;
            slot_q <= '0;
            st_q   <= ST_RD0;
          end
        end
        ST_RD0: begin
          if (mem_req_ready) st_q <= ST_W0;
        end
        ST_W0: begin
          if (mem_rsp_valid) begin
            if (ent_match) begin
              st_q <= ST_RD1;
            end else if (slot_q == LAST_SLOT) begin
              hit_q    <= 1'b0;
              fault_q  <= 1'b0;
              rpn_q    <= '0;
              wimg_q   <= '0;
              rights_q <= '0;
              rslot_q  <= slot_q;
              done_q   <= 1'b1;
              st_q     <= ST_IDLE;
            end else begin
              slot_q <= slot_q + 1'b1;
              st_q   <= ST_RD0;
            end
          end
        end
        ST_RD1: begin
          if (mem_req_ready) st_q <= ST_W1;
        end
        ST_W1: begin
          if (mem_rsp_valid) begin
            hit_q    <= 1'b1;
            fault_q  <= !dec_allowed;
            rpn_q    <= mem_rsp_data[31:12];
            wimg_q   <= mem_rsp_data[6:3];
            rights_q <= dec_rights;
            rslot_q  <= slot_q;
            wb_q     <= upd_word;
            if (dec_allowed && (upd_word != mem_rsp_data)) begin
              st_q <= ST_WB;
            end else begin
              done_q <= 1'b1;
              st_q   <= ST_IDLE;
            end
          end
        end
        ST_WB: begin
          if (mem_req_ready) begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign done       = done_q;
  assign hit        = hit_q;
  assign fault      = fault_q;
  assign res_rpn    = rpn_q;
  assign res_wimg   = wimg_q;
  assign res_rights = rights_q;
  assign res_slot   = rslot_q;
endmodule

// File: rtl/hpt_group_search_chk.sv
module hpt_group_search_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic        mem_req_write,
  input logic [31:0] mem_req_addr,
  input logic [31:0] mem_req_wdata,
  input logic        mem_rsp_valid,
  input logic        done,
  input logic        hit,
  input logic        fault
);
  logic rd_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_pend <= 1'b0;
    else if (mem_req_valid && mem_req_ready && !mem_req_write) rd_pend <= 1'b1;
    else if (mem_rsp_valid) rd_pend <= 1'b0;
  end

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata));

  assert_idle_no_mem_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid);

  assert_one_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_write |-> !rd_pend);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_fault_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault |-> hit);

  assert_align_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[1:0] == 2'b00);

  assert_wb_ref_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write |-> mem_req_wdata[8] && mem_req_addr[2]);
endmodule

bind hpt_group_search hpt_group_search_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write),
  .mem_req_addr (mem_req_addr),
  .mem_req_wdata(mem_req_wdata),
  .mem_rsp_valid(mem_rsp_valid),
  .done         (done),
  .hit          (hit),
  .fault        (fault)
);

// File: tb/hpt_group_search_test.sv
`timescale 1ns/1ps
module hpt_group_search_test;
  localparam int HW = 19;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [31:0]   cfg_table = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [HW-1:0] req_hash = '0;
  logic [31:0]   req_cmp = '0;
  logic [2:0]    req_seg_attr = '0;
  logic          req_user = 1'b0;
  logic [1:0]    req_acc = '0;
  logic          mem_req_valid;
  logic          mem_req_ready = 1'b1;
  logic          mem_req_write;
  logic [31:0]   mem_req_addr;
  logic [31:0]   mem_req_wdata;
  logic          mem_rsp_valid = 1'b0;
  logic [31:0]   mem_rsp_data = '0;
  logic          done, hit, fault;
  logic [19:0]   res_rpn;
  logic [3:0]    res_wimg;
  logic [2:0]    res_rights;
  logic [2:0]    res_slot;

  hpt_group_search uut (
    .clk(clk), .rst_n(rst_n), .cfg_table(cfg_table),
    .req_valid(req_valid), .req_ready(req_ready), .req_hash(req_hash),
    .req_cmp(req_cmp), .req_seg_attr(req_seg_attr), .req_user(req_user),
    .req_acc(req_acc), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .hit(hit), .fault(fault),
    .res_rpn(res_rpn), .res_wimg(res_wimg), .res_rights(res_rights),
    .res_slot(res_slot)
  );

  int checks = 0;
  int errors = 0;

  logic [31:0] grp [16];
  logic [31:0] grp_base = '0;
  int          rd_idx [32];
  int          n_rd = 0;
  int          n_wr = 0;
  logic [31:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  int          bad_addr = 0;
  int          overlap = 0;
  logic        stall_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  int          rsp_cnt = 0;
  logic [31:0] rsp_hold = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder: everything happens on the falling edge
  initial begin
    logic [31:0] off;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (rsp_cnt > 0) begin
        rsp_cnt--;
        if (rsp_cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = rsp_hold;
        end
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mem_req_ready = stall_en ? lfsr[0] : 1'b1;
      if (rst_n && mem_req_valid && mem_req_ready) begin
        off = mem_req_addr - grp_base;
        if (mem_req_addr < grp_base || off >= 32'd64) begin
          bad_addr++;
        end else if (mem_req_write) begin
          n_wr++;
          wr_addr = mem_req_addr;
          wr_data = mem_req_wdata;
          grp[off[5:2]] = mem_req_wdata;
        end else begin
          if (rsp_cnt != 0) overlap++;
          if (n_rd < 32) rd_idx[n_rd] = int'(off[5:2]);
          n_rd++;
          rsp_hold = grp[off[5:2]];
          rsp_cnt  = 1 + int'(lfsr[1]);
        end
      end
    end
  end

  task automatic run_case(input logic [31:0] cfg_v, input logic [HW-1:0] hash_v,
                          input logic [31:0] cmp_v, input logic [2:0] attr_v,
                          input logic user_v, input logic [1:0] acc_v);
    int          s;
    int          exp_rd;
    logic [31:0] w1, nw, tmask, w0;
    logic        key, er, ew, ex, allow, exp_wr;
    // R1: group address computed from the formula
    tmask    = {7'd0, cfg_v[8:0], 16'hFFFF};
    grp_base = (cfg_v & 32'hFFFF0000) + ((32'(hash_v) * 32'd64) & tmask);
    // R2/R3: first matching slot
    s = -1;
    for (int k = 0; k < 8; k++) begin
      w0 = grp[2*k];
      if (s < 0 && w0[31] && (((w0 ^ cmp_v) & 32'h7FFFFFBF) == 32'd0)) s = k;
    end
    w1 = (s >= 0) ? grp[2*s+1] : 32'd0;
    // R4/R5/R6
    key = user_v ? attr_v[1] : attr_v[2];
    if (key) begin
      er = (w1[1:0] != 2'd0);
      ew = (w1[1:0] == 2'd2);
    end else begin
      er = 1'b1;
      ew = (w1[1:0] != 2'd3);
    end
    ex = !attr_v[0];
    allow = (acc_v == 2'd1) ? ew : (acc_v == 2'd2) ? ex : er;
    nw = w1 | 32'h100 | ((acc_v == 2'd1) ? 32'h80 : 32'h0);
    exp_wr = (s >= 0) && allow && (nw != w1);
    exp_rd = (s < 0) ? 8 : s + 2;

    n_rd = 0; n_wr = 0; bad_addr = 0; overlap = 0;
    cfg_table = cfg_v; req_hash = hash_v; req_cmp = cmp_v;
    req_seg_attr = attr_v; req_user = user_v; req_acc = acc_v;
    chk(req_ready == 1'b1, "R10 ready when idle", 32'(req_ready), 32'd1);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);

    chk(hit == (s >= 0), "R2 hit", 32'(hit), 32'(s >= 0));
    chk(fault == ((s >= 0) && !allow), "R7 fault", 32'(fault), 32'((s >= 0) && !allow));
    chk(n_rd == exp_rd, "R2 read count", 32'(n_rd), 32'(exp_rd));
    for (int k = 0; k < exp_rd && k < n_rd; k++) begin
      int e = (s >= 0 && k == exp_rd - 1) ? 2*s + 1 : 2*k;
      chk(rd_idx[k] == e, "R1 read word order", 32'(rd_idx[k]), 32'(e));
    end
    chk(bad_addr == 0, "R1 address inside group", 32'(bad_addr), 32'd0);
    chk(overlap == 0, "R10 single read in flight", 32'(overlap), 32'd0);
    chk(n_wr == int'(exp_wr), "R8 write count", 32'(n_wr), 32'(exp_wr));
    if (exp_wr && n_wr == 1) begin
      chk(wr_addr == grp_base + 32'(8*s + 4), "R8 write address", wr_addr, grp_base + 32'(8*s + 4));
      chk(wr_data == nw, "R8 write data", wr_data, nw);
    end
    if (s >= 0) begin
      chk(res_rights == {ex, ew, er}, "R5 R6 rights", 32'(res_rights), 32'({ex, ew, er}));
      chk(res_rpn == w1[31:12], "R9 rpn", 32'(res_rpn), 32'(w1[31:12]));
      chk(res_wimg == w1[6:3], "R9 wimg", 32'(res_wimg), 32'(w1[6:3]));
      chk(res_slot == 3'(s), "R9 slot", 32'(res_slot), 32'(s));
    end
    @(negedge clk);
    chk(done == 1'b0, "R11 done single pulse", 32'(done), 32'd0);
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] cfgs [3];
    logic [31:0] cmp_v;
    cfgs[0] = 32'h0012_0003;
    cfgs[1] = 32'hABCD_01FF;
    cfgs[2] = 32'h0040_0000;
    for (int i = 0; i < 16; i++) grp[i] = '0;

    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R11 done low in reset", 32'(done), 32'd0);
    chk(mem_req_valid == 1'b0, "R10 no request in reset", 32'(mem_req_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready after reset", 32'(req_ready), 32'd1);

    // R1 R2 R3: match position sweep, s == 8 is a full miss
    stall_en = 1'b1;
    for (int c = 0; c < 3; c++) begin
      for (int s = 0; s <= 8; s++) begin
        cmp_v = 32'h2468_AC80 ^ 32'(s * 32'h0101_0101) ^ 32'(c);
        for (int k = 0; k < 8; k++) begin
          logic [31:0] w0;
          w0 = {1'b1, cmp_v[30:0]};
          if (k < s) begin
            if (k % 2 == 0) w0[31] = 1'b0;
            else w0 = w0 ^ (32'h1 << ((k * 7) % 31));
          end else if (k == s && (s % 2 == 1)) begin
            w0[6] = ~w0[6];
          end
          grp[2*k]   = w0;
          grp[2*k+1] = {20'(k * 4099 + s * 77 + 291), 3'b000, 2'b00, 4'(k + c), 1'b0, 2'(k)};
        end
        run_case(cfgs[c], HW'(32'h5A3C3 ^ (s * 1237) ^ (c * 99)), cmp_v, 3'b000, 1'b0, 2'd0);
      end
    end

    // R4 R5 R6 R7 R8: rights and write-back sweep, match at slot 3
    for (int pp = 0; pp < 4; pp++)
      for (int u = 0; u < 2; u++)
        for (int kb = 0; kb < 2; kb++)
          for (int nx = 0; nx < 2; nx++)
            for (int acc = 0; acc < 4; acc++) begin
              logic [2:0] attr;
              int rc;
              stall_en = ((pp + acc) % 2) == 1;
              rc = (pp + acc + kb) % 4;
              cmp_v = 32'h1357_9B3F;
              for (int k = 0; k < 8; k++) begin
                grp[2*k]   = (k == 3) ? {1'b1, cmp_v[30:0]} : {1'b0, cmp_v[30:0]};
                grp[2*k+1] = {20'(32'hF00D1 + k + pp * 16), 3'b000, 1'(rc >> 1), 1'(rc), 4'(pp + 5), 1'b1, 2'(pp)};
              end
              if (u == 1) attr = {1'(kb == 0), 1'(kb), 1'(nx)};
              else        attr = {1'(kb), 1'(kb == 0), 1'(nx)};
              run_case(32'h0012_0003, HW'(32'h01234 + pp), cmp_v, attr, 1'(u), 2'(acc));
            end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule